// File: doc/BRIEF.md
# Interrupt Controller Register Window

This block gives a bus master reach into the configuration state of an interrupt router. The router has more registers than the address range the block occupies, so access is indirect. Software first writes an 8-bit index into a select register. It then reads or writes the selected register 32 bits at a time through a data window. The registers behind the window are an identifier, a version word, an arbitration word, and one 64-bit routing entry per interrupt input. Each routing entry is reached through two consecutive indices: the even index holds the lower half and the odd index holds the upper half. When the block is built as version 0x20, a third offset accepts end-of-interrupt writes. Such a write releases level-triggered entries whose vector matches the written value.

Two bits of every routing entry belong to the delivery logic and not to software. The first is the remote-busy flag (bit 14). The delivery logic sets it when it sends a level-triggered request, and an end-of-interrupt write clears it. The second is the pending flag (bit 12). It mirrors a live input from the delivery logic. Software writes never alter either bit. The one exception: any write that leaves an entry edge-triggered clears the remote-busy flag. After every accepted entry write, the block raises a one-cycle scan request, so that the delivery logic re-examines pending inputs against the new configuration.

The bus side uses a request/ready handshake controlled by a five-state machine:
- IDLE accepts a request.
- RESP presents read data.
- COMMIT writes the captured half-entry into the table.
- SCAN raises the scan request.
- EOI applies an end-of-interrupt.

The transitions are:
- IDLE→RESP on an accepted read.
- IDLE→COMMIT on an accepted in-range entry write.
- IDLE→EOI on an accepted valid end-of-interrupt write.
- IDLE→IDLE on any other write, which takes effect at acceptance.
- COMMIT→SCAN.
- RESP→IDLE, SCAN→IDLE and EOI→IDLE.

Top module: `irq_reg_window`

## Requirements
- R1: Only address bits [7:0] are decoded; the select register sits at offset 0x00 and is read and written with any access size; offset 0x10 is the data window, offset 0x40 the end-of-interrupt port, every other offset reads 0 and ignores writes.
- R2: A window or end-of-interrupt access whose size input is not 4 (bytes) is ignored; such a read still completes and returns 0.
- R3: Select indices 0x00 (identifier) and 0x02 (arbitration) both read the 4-bit identifier in bits [27:24], others 0; a window write at index 0x00 updates only that field from data bits [27:24]; writes at indices 0x01 and 0x02 change nothing.
- R4: Select index 0x01 reads the VERSION parameter in bits [7:0] and NUM_ENT−1 in bits [23:16].
- R5: An index at or above 0x10 selects entry (index−0x10)>>1, upper half when the index is odd and lower half when it is even; an entry number at or beyond NUM_ENT, or an index 0x03..0x0F, reads 0 and ignores writes.
- R6: An entry resets to 0x00000000_00010000 (masked); writable bits are [11:0], 13, 15 (1 = level), 16 (mask) and [63:48]; all other bits read 0.
- R7: Bits 12 (pending, mirroring input pend) and 14 (remote-busy) are not changed by entry writes.
- R8: An entry write that leaves bit 15 at 0 clears remote-busy; a write leaving it at 1 keeps it.
- R9: An accepted, size-4, in-range entry write raises scan_req for exactly one cycle, two clock edges after acceptance; no other access raises it.
- R10: With VERSION 0x20, a size-4 write at offset 0x40 pulses eoi_valid for one cycle with eoi_vector = data[7:0] and clears remote-busy on every level entry whose bit-field [7:0] equals it; with any other VERSION the write is ignored.
- R11: ready is high only in IDLE; a request is accepted on a clock edge with req and ready high; read data appears with rvalid for one cycle right after the accepting edge.
- R12: A pulse on rirr_set[i] sets entry i remote-busy; an end-of-interrupt or edge write clearing it in the same cycle wins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Access request |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | ADDR_W | Byte address, bits [7:0] decoded |
| size | input | 3 | Access size in bytes |
| wdata | input | 32 | Write data |
| ready | output | 1 | Block can accept a request |
| rvalid | output | 1 | Read data valid |
| rdata | output | 32 | Read data |
| rirr_set | input | NUM_ENT | Per-entry remote-busy set pulses from delivery logic |
| pend | input | NUM_ENT | Per-entry pending level from delivery logic |
| scan_req | output | 1 | Re-scan request after an entry write |
| eoi_valid | output | 1 | End-of-interrupt accepted |
| eoi_vector | output | 8 | Vector of the end-of-interrupt |

## Verification
The bench builds two copies that share one bus: one with the defaults (24 entries, version 0x20) and one with 4 entries and version 0x11. The small copy puts indices that are valid in the large table beyond its last entry, which shows the out-of-range rule at a reachable index. It also reports its own entry count in the version word. Because the small copy is version 0x11, the same end-of-interrupt write must release a busy entry in one copy and leave it busy in the other.

// File: rtl/irqwin_pkg.sv
package irqwin_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RESP,
        ST_COMMIT,
        ST_SCAN,
        ST_EOI
    } win_state_e;

    typedef enum logic [2:0] {
        TGT_SEL,
        TGT_ID,
        TGT_VER,
        TGT_ARB,
        TGT_ENT,
        TGT_EOI,
        TGT_NONE
    } win_tgt_e;

    localparam logic [7:0] OFF_SEL = 8'h00;
    localparam logic [7:0] OFF_WIN = 8'h10;
    localparam logic [7:0] OFF_EOI = 8'h40;

    localparam logic [7:0] IDX_ID  = 8'h00;
    localparam logic [7:0] IDX_VER = 8'h01;
    localparam logic [7:0] IDX_ARB = 8'h02;
    localparam logic [7:0] IDX_TBL = 8'h10;

    localparam int B_PEND = 12;
    localparam int B_RIRR = 14;
    localparam int B_TRIG = 15;

    localparam logic [63:0] ENT_RW_MASK = 64'hFFFF_0000_0001_AFFF;
    localparam logic [63:0] ENT_RESET   = 64'h0000_0000_0001_0000;

endpackage

// File: rtl/irqwin_decode.sv
module irqwin_decode
    import irqwin_pkg::*;
#(
    parameter int NUM_ENT = 24,
    parameter bit EOI_EN  = 1'b1,
    parameter int IDX_W   = 5
) (
    input  logic [7:0]       addr8,
    input  logic [7:0]       sel,
    input  logic [2:0]       size,
    output win_tgt_e         tgt,
    output logic [IDX_W-1:0] ent_idx,
    output logic             ent_hi
);

    logic       size_ok;
    logic [7:0] rel;
    logic       in_tbl;

    always_comb begin
        size_ok = (size == 3'd4);
        rel     = sel - IDX_TBL;
        in_tbl  = (sel >= IDX_TBL) && ({1'b0, rel[7:1]} < 8'(NUM_ENT));
        ent_idx = rel[IDX_W:1];
        ent_hi  = sel[0];
        tgt     = TGT_NONE;
        unique case (addr8)
            OFF_SEL: tgt = TGT_SEL;
            OFF_WIN: begin
                if (size_ok) begin
                    if (sel == IDX_ID)       tgt = TGT_ID;
                    else if (sel == IDX_VER) tgt = TGT_VER;
                    else if (sel == IDX_ARB) tgt = TGT_ARB;
                    else if (in_tbl)         tgt = TGT_ENT;
                    else                     tgt = TGT_NONE;
                end
            end
            OFF_EOI: begin
                if (size_ok && EOI_EN) tgt = TGT_EOI;
            end
            default: tgt = TGT_NONE;
        endcase
    end

endmodule

// File: rtl/irqwin_table.sv
module irqwin_table
    import irqwin_pkg::*;
#(
    parameter int NUM_ENT = 24,
    parameter int IDX_W   = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic               wr_hi,
    input  logic [31:0]        wr_data,
    input  logic               eoi_en,
    input  logic [7:0]         eoi_vec,
    input  logic [NUM_ENT-1:0] rirr_set,
    input  logic [NUM_ENT-1:0] pend,
    input  logic [IDX_W-1:0]   rd_idx,
    input  logic               rd_hi,
    output logic [31:0]        rd_data,
    output logic [NUM_ENT-1:0] rirr_vec
);

    logic [63:0] view [NUM_ENT];

    for (genvar g = 0; g < NUM_ENT; g++) begin : g_ent
        logic [63:0] cfg_q;
        logic [63:0] cfg_new;
        logic        rirr_q;
        logic        hit_wr;
        logic        hit_eoi;

        always_comb begin
            hit_wr  = wr_en && (wr_idx == IDX_W'(g));
            cfg_new = wr_hi ? {wr_data, cfg_q[31:0]} : {cfg_q[63:32], wr_data};
            cfg_new = cfg_new & ENT_RW_MASK;
            hit_eoi = eoi_en && cfg_q[B_TRIG] && (cfg_q[7:0] == eoi_vec);
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cfg_q  <= ENT_RESET;
                rirr_q <= 1'b0;
            end else begin
                if (hit_wr) begin
                    cfg_q <= cfg_new;
                end
                if (hit_wr && !cfg_new[B_TRIG]) begin
                    rirr_q <= 1'b0;
                end else if (hit_eoi) begin
                    rirr_q <= 1'b0;
                end else if (rirr_set[g]) begin
                    rirr_q <= 1'b1;
                end
            end
        end

        always_comb begin
            view[g]         = cfg_q;
            view[g][B_RIRR] = rirr_q;
            view[g][B_PEND] = pend[g];
        end

        assign rirr_vec[g] = rirr_q;
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_ENT; i++) begin
            if (rd_idx == IDX_W'(i)) begin
                rd_data = rd_hi ? view[i][63:32] : view[i][31:0];
            end
        end
    end

endmodule

// File: rtl/irqwin_fsm.sv
module irqwin_fsm
    import irqwin_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req,
    input  logic       we,
    input  win_tgt_e   tgt,
    output win_state_e state,
    output logic       ready,
    output logic       rvalid,
    output logic       commit_en,
    output logic       scan_req,
    output logic       eoi_valid
);

    win_state_e state_d;

    always_comb begin
        state_d = state;
        unique case (state)
            ST_IDLE: begin
                if (req) begin
                    if (!we)                 state_d = ST_RESP;
                    else if (tgt == TGT_ENT) state_d = ST_COMMIT;
                    else if (tgt == TGT_EOI) state_d = ST_EOI;
                    else                     state_d = ST_IDLE;
                end
            end
            ST_RESP:   state_d = ST_IDLE;
            ST_COMMIT: state_d = ST_SCAN;
            ST_SCAN:   state_d = ST_IDLE;
            ST_EOI:    state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_d;
    end

    always_comb begin
        ready     = 1'b0;
        rvalid    = 1'b0;
        commit_en = 1'b0;
        scan_req  = 1'b0;
        eoi_valid = 1'b0;
        unique case (state)
            ST_IDLE:   ready     = 1'b1;
            ST_RESP:   rvalid    = 1'b1;
            ST_COMMIT: commit_en = 1'b1;
            ST_SCAN:   scan_req  = 1'b1;
            ST_EOI:    eoi_valid = 1'b1;
            default:   ready     = 1'b0;
        endcase
    end

endmodule

// File: rtl/irq_reg_window.sv
module irq_reg_window
    import irqwin_pkg::*;
#(
    parameter int         NUM_ENT = 24,
    parameter logic [7:0] VERSION = 8'h20,
    parameter int         ADDR_W  = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req,
    input  logic               we,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [2:0]         size,
    input  logic [31:0]        wdata,
    output logic               ready,
    output logic               rvalid,
    output logic [31:0]        rdata,
    input  logic [NUM_ENT-1:0] rirr_set,
    input  logic [NUM_ENT-1:0] pend,
    output logic               scan_req,
    output logic               eoi_valid,
    output logic [7:0]         eoi_vector
);

    localparam int IDX_W  = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1;
    localparam bit EOI_EN = (VERSION == 8'h20);
    localparam logic [31:0] VER_WORD = {8'h00, 8'(NUM_ENT - 1), 8'h00, VERSION};

    logic [7:0]       sel_q;
    logic [3:0]       id_q;
    logic [31:0]      cap_data;
    logic [IDX_W-1:0] cap_idx;
    logic             cap_hi;
    logic [31:0]      rdata_q;

    win_tgt_e         tgt;
    logic [IDX_W-1:0] dec_idx;
    logic             dec_hi;
    win_state_e       state;
    logic             commit_en;
    logic             accept;
    logic [31:0]      tbl_rd;
    logic [31:0]      rd_mux;
    logic [NUM_ENT-1:0] rirr_vec;
    logic             unused_addr_hi;

    if (ADDR_W > 8) begin : g_addr_hi
        assign unused_addr_hi = ^addr[ADDR_W-1:8];
    end else begin : g_addr_exact
        assign unused_addr_hi = 1'b0;
    end

    irqwin_decode #(
        .NUM_ENT(NUM_ENT),
        .EOI_EN (EOI_EN),
        .IDX_W  (IDX_W)
    ) u_dec (
        .addr8  (addr[7:0]),
        .sel    (sel_q),
        .size   (size),
        .tgt    (tgt),
        .ent_idx(dec_idx),
        .ent_hi (dec_hi)
    );

    irqwin_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (req),
        .we       (we),
        .tgt      (tgt),
        .state    (state),
        .ready    (ready),
        .rvalid   (rvalid),
        .commit_en(commit_en),
        .scan_req (scan_req),
        .eoi_valid(eoi_valid)
    );

    irqwin_table #(
        .NUM_ENT(NUM_ENT),
        .IDX_W  (IDX_W)
    ) u_tbl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (commit_en),
        .wr_idx  (cap_idx),
        .wr_hi   (cap_hi),
        .wr_data (cap_data),
        .eoi_en  (eoi_valid),
        .eoi_vec (cap_data[7:0]),
        .rirr_set(rirr_set),
        .pend    (pend),
        .rd_idx  (dec_idx),
        .rd_hi   (dec_hi),
        .rd_data (tbl_rd),
        .rirr_vec(rirr_vec)
    );

    assign accept = req && ready;

    always_comb begin
        unique case (tgt)
            TGT_SEL: rd_mux = {24'h0, sel_q};
            TGT_ID,
            TGT_ARB: rd_mux = {4'h0, id_q, 24'h0};
            TGT_VER: rd_mux = VER_WORD;
            TGT_ENT: rd_mux = tbl_rd;
            default: rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q    <= '0;
            id_q     <= '0;
            cap_data <= '0;
            cap_idx  <= '0;
            cap_hi   <= 1'b0;
            rdata_q  <= '0;
        end else if (accept) begin
            cap_data <= wdata;
            cap_idx  <= dec_idx;
            cap_hi   <= dec_hi;
            if (we) begin
                if (tgt == TGT_SEL) sel_q <= wdata[7:0];
                if (tgt == TGT_ID)  id_q  <= wdata[27:24];
            end else begin
                rdata_q <= rd_mux;
            end
        end
    end

    assign rdata      = rdata_q;
    assign eoi_vector = cap_data[7:0];

endmodule

// File: rtl/irqwin_chk.sv
module irqwin_chk #(
    parameter int NUM_ENT = 24,
    parameter int IDX_W   = 5
) (
    input logic               clk,
    input logic               rst_n,
    input logic               req,
    input logic               we,
    input logic               ready,
    input logic [7:0]         addr8,
    input logic [2:0]         size,
    input logic               rvalid,
    input logic               scan_req,
    input logic               eoi_valid,
    input logic               commit_en,
    input logic [IDX_W-1:0]   cap_idx,
    input logic               cap_hi,
    input logic [31:0]        cap_data,
    input logic [NUM_ENT-1:0] rirr_vec,
    input logic [3:0]         id_q
);

    AST_READ_RESPONDS: assert property (@(posedge clk) disable iff (!rst_n)
        (req && ready && !we) |=> rvalid); // R11

    AST_SCAN_FOLLOWS_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        commit_en |=> scan_req); // R9

    AST_EDGE_CLEARS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_en && !cap_hi && !cap_data[15]) |=> !rirr_vec[$past(cap_idx)]); // R8

    AST_EOI_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        eoi_valid |-> $past(req && ready && we && addr8 == 8'h40 && size == 3'd4)); // R10

    AST_ID_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !(req && ready && we) |=> $stable(id_q)); // R3

    AST_ONE_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rvalid, scan_req, eoi_valid, ready})); // R11

endmodule

bind irq_reg_window irqwin_chk #(
    .NUM_ENT(NUM_ENT),
    .IDX_W  (IDX_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .req      (req),
    .we       (we),
    .ready    (ready),
    .addr8    (addr[7:0]),
    .size     (size),
    .rvalid   (rvalid),
    .scan_req (scan_req),
    .eoi_valid(eoi_valid),
    .commit_en(commit_en),
    .cap_idx  (cap_idx),
    .cap_hi   (cap_hi),
    .cap_data (cap_data),
    .rirr_vec (rirr_vec),
    .id_q     (id_q)
);

// File: tb/sim_irq_reg_window.sv
module sim_irq_reg_window;

    localparam int CLK_PERIOD = 10;
    localparam int N0 = 24;
    localparam int N1 = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic        we = 1'b0;
    logic [11:0] addr = '0;
    logic [2:0]  size = 3'd4;
    logic [31:0] wdata = '0;
    logic [N0-1:0] rirr_set = '0;
    logic [N0-1:0] pend = '0;

    logic        ready0, rvalid0, scan0, eoiv0;
    logic [31:0] rdata0;
    logic [7:0]  eoivec0;
    logic        ready1, rvalid1, scan1, eoiv1;
    logic [31:0] rdata1;
    logic [7:0]  eoivec1;

    typedef struct {
        logic [31:0] e0;
        logic [31:0] e1;
        bit          c1;
        string       tag;
    } item_t;
    item_t sbq[$];

    int nchk = 0;
    int nerr = 0;
    int scans0 = 0, scans1 = 0, eois0 = 0, eois1 = 0;
    logic [7:0] last_vec0 = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_reg_window u0 (
        .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr), .size(size),
        .wdata(wdata), .ready(ready0), .rvalid(rvalid0), .rdata(rdata0),
        .rirr_set(rirr_set), .pend(pend), .scan_req(scan0),
        .eoi_valid(eoiv0), .eoi_vector(eoivec0)
    );

    irq_reg_window #(.NUM_ENT(N1), .VERSION(8'h11)) u1 (
        .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr), .size(size),
        .wdata(wdata), .ready(ready1), .rvalid(rvalid1), .rdata(rdata1),
        .rirr_set(rirr_set[N1-1:0]), .pend(pend[N1-1:0]), .scan_req(scan1),
        .eoi_valid(eoiv1), .eoi_vector(eoivec1)
    );

    task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
        nchk++;
        if (got !== exp) begin
            nerr++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // monitor: scoreboard pop on each read response, event counting
    always @(negedge clk) begin
        if (rst_n) begin
            if (scan0) scans0++;
            if (scan1) scans1++;
            if (eoiv0) begin eois0++; last_vec0 = eoivec0; end
            if (eoiv1) eois1++;
            if (rvalid0) begin
                if (sbq.size() == 0) begin
                    check("R11 unexpected rvalid", 32'd1, 32'd0);
                end else begin
                    item_t it;
                    it = sbq.pop_front();
                    check({it.tag, " u0"}, rdata0, it.e0);
                    if (it.c1) begin
                        check({it.tag, " u1"}, rdata1, it.e1);
                    end
                end
            end
        end
    end

    task automatic bus(bit w, logic [11:0] a, logic [2:0] s, logic [31:0] d);
        @(negedge clk);
        while (!ready0) @(negedge clk);
        req = 1'b1; we = w; addr = a; size = s; wdata = d;
        @(negedge clk);
        req = 1'b0; we = 1'b0;
    endtask

    task automatic wr(logic [11:0] a, logic [2:0] s, logic [31:0] d);
        bus(1'b1, a, s, d);
    endtask

    task automatic rd(logic [11:0] a, logic [2:0] s, logic [31:0] e0,
                      logic [31:0] e1, bit c1, string tag);
        item_t it;
        it.e0 = e0; it.e1 = e1; it.c1 = c1; it.tag = tag;
        sbq.push_back(it);
        bus(1'b0, a, s, 32'h0);
    endtask

    task automatic setsel(logic [7:0] v);
        wr(12'h000, 3'd4, {24'h0, v});
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        nchk++; nerr++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        int s0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        check("R11 ready after reset", {31'h0, ready0}, 32'd1);
        check("R11 rvalid after reset", {31'h0, rvalid0}, 32'd0);

        // R1 select register reset value and readback
        rd(12'h000, 3'd4, 32'h0, 32'h0, 1'b1, "R1 select reset");
        wr(12'h000, 3'd1, 32'h0000_0002);
        rd(12'h000, 3'd2, 32'h2, 32'h2, 1'b1, "R1 select any size");
        rd(12'h010, 3'd4, 32'h0, 32'h0, 1'b1, "R3 arb reset");

        // R4 version word
        setsel(8'h01);
        rd(12'h010, 3'd4, 32'h0017_0020, 32'h0003_0011, 1'b1, "R4 version word");
        rd(12'h110, 3'd4, 32'h0017_0020, 32'h0003_0011, 1'b1, "R1 alias addr 0x110");
        wr(12'h010, 3'd4, 32'hFFFF_FFFF);
        rd(12'h010, 3'd4, 32'h0017_0020, 32'h0003_0011, 1'b1, "R3 version write ignored");

        // R3 identifier / arbitration
        setsel(8'h00);
        s0 = scans0;
        wr(12'h010, 3'd4, 32'hFFFF_FFFF);
        settle();
        check("R9 no scan on id write", scans0 - s0, 32'd0);
        rd(12'h010, 3'd4, 32'h0F00_0000, 32'h0F00_0000, 1'b1, "R3 id field");
        setsel(8'h02);
        rd(12'h010, 3'd4, 32'h0F00_0000, 32'h0F00_0000, 1'b1, "R3 arb mirrors id");
        wr(12'h010, 3'd4, 32'h0000_0000);
        setsel(8'h00);
        rd(12'h010, 3'd4, 32'h0F00_0000, 32'h0F00_0000, 1'b1, "R3 arb write ignored");

        // R2 size rules
        wr(12'h010, 3'd1, 32'h0000_0000);
        rd(12'h010, 3'd4, 32'h0F00_0000, 32'h0F00_0000, 1'b1, "R2 short write ignored");
        rd(12'h010, 3'd2, 32'h0, 32'h0, 1'b1, "R2 short read zero");
        rd(12'h020, 3'd4, 32'h0, 32'h0, 1'b1, "R1 unknown offset zero");

        // R6 entry reset and writable bits
        setsel(8'h10);
        rd(12'h010, 3'd4, 32'h0001_0000, 32'h0001_0000, 1'b1, "R6 entry reset");
        s0 = scans0;
        wr(12'h010, 3'd4, 32'hFFFF_FFFF);
        settle();
        check("R9 scan after entry write", scans0 - s0, 32'd1);
        rd(12'h010, 3'd4, 32'h0001_AFFF, 32'h0001_AFFF, 1'b1, "R6 low rw bits");
        setsel(8'h11);
        rd(12'h010, 3'd4, 32'h0, 32'h0, 1'b1, "R5 upper half reset");
        wr(12'h010, 3'd4, 32'hFFFF_FFFF);
        rd(12'h010, 3'd4, 32'hFFFF_0000, 32'hFFFF_0000, 1'b1, "R6 high rw bits");
        s0 = scans0;
        wr(12'h010, 3'd2, 32'h0);
        settle();
        check("R9 no scan on short entry write", scans0 - s0, 32'd0);

        // R12 / R7 remote-busy on entry 3 (index 0x16)
        setsel(8'h16);
        wr(12'h010, 3'd4, 32'h0000_8033);
        @(negedge clk); rirr_set[3] = 1'b1;
        @(negedge clk); rirr_set[3] = 1'b0;
        rd(12'h010, 3'd4, 32'h0000_C033, 32'h0000_C033, 1'b1, "R12 busy set");
        wr(12'h010, 3'd4, 32'h0000_8033);
        rd(12'h010, 3'd4, 32'h0000_C033, 32'h0000_C033, 1'b1, "R7 busy survives level write");

        // R10 end-of-interrupt
        wr(12'h040, 3'd2, 32'h33);
        wr(12'h040, 3'd4, 32'h34);
        rd(12'h010, 3'd4, 32'h0000_C033, 32'h0000_C033, 1'b1, "R10 no match or short");
        wr(12'h040, 3'd4, 32'h33);
        settle();
        rd(12'h010, 3'd4, 32'h0000_8033, 32'h0000_C033, 1'b1, "R10 eoi clears by version");
        check("R10 eoi pulses u0", eois0, 32'd2);
        check("R10 eoi vector", {24'h0, last_vec0}, 32'h33);
        check("R10 no eoi on old version", eois1, 32'd0);

        // R8 edge write clears busy, entry 4 (index 0x18, beyond u1)
        setsel(8'h18);
        wr(12'h010, 3'd4, 32'h0000_8044);
        @(negedge clk); rirr_set[4] = 1'b1;
        @(negedge clk); rirr_set[4] = 1'b0;
        rd(12'h010, 3'd4, 32'h0000_C044, 32'h0, 1'b1, "R5 u1 out of range");
        wr(12'h010, 3'd4, 32'h0000_0044);
        rd(12'h010, 3'd4, 32'h0000_0044, 32'h0, 1'b1, "R8 edge clears busy");

        // R7 pending bit, entry 2 (index 0x14)
        pend[2] = 1'b1;
        setsel(8'h14);
        rd(12'h010, 3'd4, 32'h0001_1000, 32'h0001_1000, 1'b1, "R7 pending visible");
        wr(12'h010, 3'd4, 32'h0000_0021);
        rd(12'h010, 3'd4, 32'h0000_1021, 32'h0000_1021, 1'b1, "R7 pending survives write");
        pend[2] = 1'b0;
        rd(12'h010, 3'd4, 32'h0000_0021, 32'h0000_0021, 1'b1, "R7 pending follows input");

        // R5 out of range indices
        setsel(8'h40);
        s0 = scans0;
        wr(12'h010, 3'd4, 32'hFFFF_FFFF);
        settle();
        check("R9 no scan out of range", scans0 - s0, 32'd0);
        rd(12'h010, 3'd4, 32'h0, 32'h0, 1'b1, "R5 index past table");
        setsel(8'h05);
        rd(12'h010, 3'd4, 32'h0, 32'h0, 1'b1, "R5 gap index");

        settle();
        check("R9 total scans u0", scans0, 32'd7);
        check("R9 total scans u1", scans1, 32'd5);
        check("R11 scoreboard drained", sbq.size(), 32'd0);
        finish_run();
    end

endmodule